// File: doc/BRIEF.md
# Pulse Accumulator with Event and Overflow Flags

The block is a 16-bit counter fed from one external input pin. It has two ways of counting. In edge mode every active edge of the pin adds one. In gated mode the count grows by one on every prescaler tick while the pin sits at its active level. A control bit picks the polarity: the rising edge or the high level, or else the falling edge or the low level. The pin goes through a two-stage synchronizer before any edge is detected.

Two sticky flags record what has happened. The wrap flag is set when the count goes from its maximum back to zero. The event flag is set by the counted edge in edge mode, and by the end of a gate window in gated mode. Each flag has its own interrupt enable, and the single interrupt output is the OR of the enabled flags. Software clears a flag by writing 1 to its bit. When the fast-clear option is on, any read or write of the counter clears both flags at once.

Software reaches the block through a small synchronous register bus. Reads are combinational from the address. Writes take effect on the clock edge while select and write are both high.

Top module: `pulse_accum`

## Requirements
- R1: The counter is CNT_W bits wide (16 by default). A counting event while the counter holds all ones wraps it to zero and sets the wrap flag, flags bit 0 at address 1.
- R2: The wrap flag drives `irq` only while control bit 2 (wrap interrupt enable) is 1. With both enables at 0, `irq` stays 0.
- R3: In edge mode (control bit 0 = 0), each active edge of the synchronized pin adds one to the counter and sets the event flag, flags bit 1. Control bit 1 = 0 selects rising edges and 1 selects falling edges.
- R4: In gated mode (control bit 0 = 1), the counter adds one on each cycle in which `tick` is high and the pin is at its active level: high when control bit 1 = 0, low when it is 1. The event flag is set when the pin leaves the active level, never when it enters it.
- R5: The event flag drives `irq` only while control bit 3 (event interrupt enable) is 1.
- R6: Writing the flags register (address 1) clears each flag whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R7: While control bit 4 (fast clear) is 1, any bus access to the counter (address 2), read or write, clears both flags. While it is 0, reading the counter leaves the flags unchanged.
- R8: Writing address 2 loads the counter. If a counting event falls in the same cycle, the written value is what the counter holds afterwards.
- R9: If a flag is set by hardware in the same cycle that software clears it, the flag ends up set.
- R10: After reset the counter, both flags, the control register and `irq` are 0. Address 0 reads the control register in bits 4:0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 1 | External input to count (asynchronous) |
| tick | input | 1 | Prescaler tick used in gated mode |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 = control, 1 = flags, 2 = counter |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default CNT_W of 16. That makes the wrap from 0xFFFF reachable only by loading the counter near the top through the bus and then adding two edges. A table drives both modes at both polarities with varied pulse counts and widths. Directed tests then place a flag clear in the same cycle as a flag set, place a counter write in the same cycle as a gated increment, and switch fast clear off and on while the counter is accessed.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             tick,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int CTRL_W = 5;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap_q, evt_q;
  logic [2:0]        sync_q;

  wire gated    = ctrl_q[0];
  wire pol      = ctrl_q[1];
  wire wrap_ie  = ctrl_q[2];
  wire evt_ie   = ctrl_q[3];
  wire fast_clr = ctrl_q[4];

  wire act_now  = sync_q[1] ^ pol;
  wire act_prev = sync_q[2] ^ pol;
  wire lead     = act_now & ~act_prev;
  wire trail    = act_prev & ~act_now;

  wire inc      = gated ? (tick & act_now) : lead;
  wire evt_set  = gated ? trail : lead;

  wire ctrl_wr  = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire flag_wr  = bus_sel & bus_wr & (bus_addr == 2'd1);
  wire cnt_wr   = bus_sel & bus_wr & (bus_addr == 2'd2);
  wire cnt_acc  = bus_sel & (bus_addr == 2'd2);
  wire fc_hit   = fast_clr & cnt_acc;

  wire wrap_set = inc & ~cnt_wr & (cnt_q == CNT_MAX);
  wire wrap_clr = (flag_wr & bus_wdata[0]) | fc_hit;
  wire evt_clr  = (flag_wr & bus_wdata[1]) | fc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= bus_wdata;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      wrap_q <= wrap_set | (wrap_q & ~wrap_clr);
      evt_q  <= evt_set  | (evt_q  & ~evt_clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0:    bus_rdata[CTRL_W-1:0] = ctrl_q;
      2'd1:    bus_rdata[1:0] = {evt_q, wrap_q};
      2'd2:    bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (wrap_q & wrap_ie) | (evt_q & evt_ie);

  // R1
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_wr && cnt_q == CNT_MAX) |=> (wrap_q && cnt_q == '0));

  // R2
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_ie && !evt_ie) |-> !irq);

  // R4
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !act_now && !cnt_wr) |=> $stable(cnt_q));

  // R6
  wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !(flag_wr && bus_wdata[0]) && !fc_hit) |=> wrap_q);

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(bus_wdata)));

  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> evt_q);
endmodule

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;
  logic        clk = 0, rst_n = 0, pin_in = 0, tick = 1, tick_div = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  pulse_accum #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick(tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  always @(negedge clk) tick <= tick_div ? ~tick : 1'b1;

  // {ctrl[4:0], pulses[3:0], width[3:0], exp_cnt[15:0], exp_evt}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {5'b00000, 4'd3, 4'd2, 16'd3, 1'b1},
    {5'b00010, 4'd4, 4'd3, 16'd4, 1'b1},
    {5'b00000, 4'd0, 4'd2, 16'd0, 1'b0},
    {5'b00001, 4'd2, 4'd3, 16'd6, 1'b1},
    {5'b00011, 4'd3, 4'd2, 16'd6, 1'b1},
    {5'b00001, 4'd1, 4'd5, 16'd5, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input logic idl, input int n, input int w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin_in = ~idl;
      idle(w);
      pin_in = idl;
      idle(3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd(2, d); chk("R10 counter", d, 16'h0);
    rd(1, d); chk("R10 flags", d, 16'h0);
    rd(0, d); chk("R10 control", d, 16'h0);
    rd(3, d); chk("R10 spare address", d, 16'h0);
    chk("R10 irq", {15'b0, irq}, 16'h0);

    // R3 / R4 table
    for (int v = 0; v < NV; v++) begin
      logic [4:0] c;
      c = VEC[v][29:25];
      pin_in = c[1]; idle(4);
      wr(0, {11'b0, c}); idle(4);
      wr(2, 16'h0); wr(1, 16'h3);
      pulses(c[1], int'(VEC[v][24:21]), int'(VEC[v][20:17]));
      idle(4);
      rd(2, d); chk(c[0] ? "R4 table count" : "R3 table count", d, VEC[v][16:1]);
      rd(1, d); chk(c[0] ? "R4 table flags" : "R3 table flags", d, {14'b0, VEC[v][0], 1'b0});
    end

    // R1 wrap, R2 enable
    pin_in = 0; idle(4);
    wr(0, 16'h0); idle(4);
    wr(2, 16'hFFFE); wr(1, 16'h3);
    pulses(1'b0, 2, 2); idle(4);
    rd(2, d); chk("R1 wrap count", d, 16'h0);
    rd(1, d); chk("R1 wrap flag", d, 16'h3);
    chk("R2 irq masked", {15'b0, irq}, 16'h0);
    wr(0, 16'h4);
    chk("R2 irq enabled", {15'b0, irq}, 16'h1);

    // R6 write-one-to-clear
    wr(1, 16'h2);
    rd(1, d); chk("R6 clear event only", d, 16'h1);
    wr(1, 16'h0);
    rd(1, d); chk("R6 zero write no effect", d, 16'h1);
    wr(1, 16'h1);
    rd(1, d); chk("R6 clear wrap", d, 16'h0);
    chk("R6 irq dropped", {15'b0, irq}, 16'h0);

    // R5 event interrupt enable
    wr(0, 16'h0);
    pulses(1'b0, 1, 2); idle(4);
    chk("R5 irq masked", {15'b0, irq}, 16'h0);
    wr(0, 16'h8);
    chk("R5 irq enabled", {15'b0, irq}, 16'h1);
    wr(1, 16'h3);
    chk("R5 irq after clear", {15'b0, irq}, 16'h0);

    // R4 leading edge does not flag, tick gating
    wr(0, 16'h1); idle(2);
    wr(2, 16'h0); wr(1, 16'h3);
    @(negedge clk); pin_in = 1;
    idle(6);
    rd(1, d); chk("R4 no flag on leading edge", d, 16'h0);
    rd(2, d); chk("R4 counting while active", {15'b0, d != 0}, 16'h1);
    pin_in = 0; idle(4);
    rd(1, d); chk("R4 flag on trailing edge", d, 16'h2);
    wr(2, 16'h0); wr(1, 16'h3);
    tick_div = 1;
    pulses(1'b0, 1, 10); idle(4);
    tick_div = 0;
    rd(2, d); chk("R4 half-rate tick count", d, 16'd5);

    // R7 fast clear
    wr(0, 16'h0); idle(2);
    wr(1, 16'h3);
    pulses(1'b0, 1, 2); idle(4);
    rd(2, d);
    rd(1, d); chk("R7 read keeps flags without fast clear", d, 16'h2);
    wr(0, 16'h10);
    rd(2, d);
    rd(1, d); chk("R7 counter read clears flags", d, 16'h0);
    pulses(1'b0, 1, 2); idle(4);
    wr(2, 16'h7);
    rd(1, d); chk("R7 counter write clears flags", d, 16'h0);
    rd(2, d); chk("R7 counter write value", d, 16'h7);

    // R8 write wins over same-cycle increment
    wr(0, 16'h1); idle(2);
    @(negedge clk); pin_in = 1;
    idle(5);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 2; bus_wdata = 16'h0100;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    chk("R8 write beats increment", d, 16'h0100);
    pin_in = 0; idle(4);

    // R9 set wins over same-cycle clear
    wr(0, 16'h0); idle(2);
    wr(1, 16'h3);
    @(negedge clk); pin_in = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 16'h3;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    rd(1, d); chk("R9 set beats clear", d, 16'h2);
    pin_in = 0; idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule